// File: doc/BRIEF.md
# Display Memory Address Translator

This block sits between a pixel renderer and the planar video memory. The renderer presents a 16-bit display offset and a plane number. The block rewrites the offset in two fixed stages. The first stage is a word-mode wrap that copies a high address bit onto bit 0. The second stage can put the low row-scan counter bits in place of address bits 13 and 14. The plane number is then placed above the rewritten offset to form an 18-bit physical address. That address is compared against the installed memory size, and the read returns the stored byte, or zero when the address lies beyond the installed memory.

Host writes use the same storage but skip both translation stages. A host write that lands beyond the installed size is discarded. A host write that lands in plane 2 produces a one-cycle notification carrying the written offset, so that cached character-generator data can be refreshed. The translation itself is combinational. The physical address, the read data and a valid flag appear in registers one clock after the read request.

The storage backs the low `BANK_AW` offset bits of each plane. The bounds check always uses the full 18-bit physical address.

Top module: `vmem_xlate`

## Requirements
- R1: While reset is held and directly after it, `rd_valid_q`, `rd_data_q` and `upd_valid_q` are 0.
- R2: `rd_valid_q` is 1 in exactly the cycle after a cycle with `rd_en` high, and 0 otherwise. With word mode off and both keep bits set, `rd_addr_q` equals {plane[1:0], offset} in that cycle.
- R3: With `cfg_word_mode`=1, physical address bit 0 takes offset bit 15 when `cfg_wrap_msb`=1, and offset bit 13 when `cfg_wrap_msb`=0. The other bits are not affected by this stage.
- R4: With `cfg_keep_a13`=0, physical address bit 13 takes `row_scan[0]`. With `cfg_keep_a14`=0, physical address bit 14 takes `row_scan[1]`. `row_scan` bits above 1 are ignored.
- R5: The wrap stage reads the offset before substitution. With word mode on, `cfg_wrap_msb`=0, `cfg_keep_a13`=0 and row_scan[0]=0, offset 0x2000 gives physical address 0x00001.
- R6: Only bits [1:0] of `rd_plane` and `wr_plane` are used. They form physical address bits [17:16].
- R7: An in-range read returns, one cycle after `rd_en`, the byte last written by the host at the storage index {plane[1:0], offset[BANK_AW-1:0]}.
- R8: A read whose physical address is at or above `MEM_BYTES` returns `rd_data_q`=0. Address `MEM_BYTES-1` is still in range.
- R9: A host write whose physical address {plane[1:0], offset} is at or above `MEM_BYTES` leaves the storage unchanged.
- R10: Host writes store at the untranslated offset, whatever the translation controls are set to.
- R11: An in-range host write to plane 2 sets `upd_valid_q` to 1 in the next cycle, with `upd_offset_q` holding the write offset. Writes to other planes, out-of-range writes and idle cycles leave `upd_valid_q` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word_mode | input | 1 | Enables the bit-0 wrap stage |
| cfg_wrap_msb | input | 1 | Wrap source: 1 = offset bit 15, 0 = offset bit 13 |
| cfg_keep_a13 | input | 1 | 1 keeps address bit 13, 0 substitutes row_scan[0] |
| cfg_keep_a14 | input | 1 | 1 keeps address bit 14, 0 substitutes row_scan[1] |
| row_scan | input | RS_W | Row-scan counter; only bits [1:0] are used |
| rd_en | input | 1 | Renderer read request |
| rd_plane | input | PLANE_IN_W | Renderer plane number |
| rd_offset | input | 16 | Renderer display offset |
| wr_en | input | 1 | Host write strobe |
| wr_plane | input | PLANE_IN_W | Host plane number |
| wr_offset | input | 16 | Host offset (not translated) |
| wr_data | input | 8 | Host write byte |
| rd_valid_q | output | 1 | Read result valid |
| rd_addr_q | output | 18 | Translated physical address of the read |
| rd_data_q | output | 8 | Read byte, or 0 when out of range |
| upd_valid_q | output | 1 | Plane-2 write notification |
| upd_offset_q | output | 16 | Offset carried by the notification |

## Verification
The bench builds the block with `MEM_BYTES`=0x28000, `BANK_AW`=6, `PLANE_IN_W`=8 and `RS_W`=5. With this size the range boundary falls inside plane 2, at offset 0x8000, so a single plane holds both in-range and out-of-range addresses, including the last valid byte. The small bank makes an out-of-range write alias onto a byte that has already been written, so a dropped write can be seen through a read. The wider plane and row-scan ports let the bench drive the bits the block must ignore, while all 64 control combinations are compared against a reference model.

// File: rtl/vmx_pkg.sv
`timescale 1ns/1ps
package vmx_pkg;
    localparam int OFF_W   = 16;
    localparam int PL_W    = 2;
    localparam int PHYS_W  = OFF_W + PL_W;
    localparam int DATA_W  = 8;

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  rd_valid;
        phys_t rd_addr;
        byte_t rd_data;
        logic  upd_valid;
        off_t  upd_offset;
    } store_regs_t;
endpackage

// File: rtl/vmx_wordwrap.sv
`timescale 1ns/1ps
module vmx_wordwrap #(
    parameter int OFF_W  = 16,
    parameter int SRC_LO = 13,
    parameter int SRC_HI = 15
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic             word_mode_i,
    input  logic             wrap_msb_i,
    output logic [OFF_W-1:0] off_o
);
    logic wrap_bit;

    always_comb begin
        wrap_bit = wrap_msb_i ? off_i[SRC_HI] : off_i[SRC_LO];
    end

    assign off_o[0]         = word_mode_i ? wrap_bit : off_i[0];
    assign off_o[OFF_W-1:1] = off_i[OFF_W-1:1];
endmodule

// File: rtl/vmx_rowsub.sv
`timescale 1ns/1ps
module vmx_rowsub #(
    parameter int OFF_W  = 16,
    parameter int SUB_LO = 13,
    parameter int SUB_N  = 2
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [SUB_N-1:0] keep_i,
    input  logic [SUB_N-1:0] rs_i,
    output logic [OFF_W-1:0] off_o
);
    localparam int SUB_HI = SUB_LO + SUB_N - 1;

    for (genvar b = 0; b < OFF_W; b++) begin : g_bit
        if (b >= SUB_LO && b <= SUB_HI) begin : g_sub
            assign off_o[b] = keep_i[b-SUB_LO] ? off_i[b] : rs_i[b-SUB_LO];
        end else begin : g_pass
            assign off_o[b] = off_i[b];
        end
    end
endmodule

// File: rtl/vmx_store.sv
`timescale 1ns/1ps
module vmx_store
    import vmx_pkg::*;
#(
    parameter int MEM_BYTES = 196608,
    parameter int BANK_AW   = 8,
    parameter int CHR_PLANE = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en_i,
    input  phys_t rd_phys_i,
    input  logic  wr_en_i,
    input  phys_t wr_phys_i,
    input  byte_t wr_data_i,
    output store_regs_t regs_o
);
    localparam int IDX_W = PL_W + BANK_AW;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [PHYS_W:0] LIMIT = (PHYS_W+1)'(MEM_BYTES);

    byte_t mem_q [DEPTH];
    store_regs_t r_d, r_q;

    logic             rd_in, wr_in;
    logic [IDX_W-1:0] rd_idx, wr_idx;

    always_comb begin
        rd_in  = {1'b0, rd_phys_i} < LIMIT;
        wr_in  = {1'b0, wr_phys_i} < LIMIT;
        rd_idx = {rd_phys_i[PHYS_W-1 -: PL_W], rd_phys_i[BANK_AW-1:0]};
        wr_idx = {wr_phys_i[PHYS_W-1 -: PL_W], wr_phys_i[BANK_AW-1:0]};
    end

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = rd_en_i;
        if (rd_en_i) begin
            r_d.rd_addr = rd_phys_i;
            r_d.rd_data = rd_in ? mem_q[rd_idx] : '0;
        end
        r_d.upd_valid = wr_en_i && wr_in
                        && (wr_phys_i[PHYS_W-1 -: PL_W] == PL_W'(CHR_PLANE));
        if (r_d.upd_valid) begin
            r_d.upd_offset = wr_phys_i[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && wr_in) begin
            mem_q[wr_idx] <= wr_data_i;
        end
    end

    assign regs_o = r_q;
endmodule

// File: rtl/vmem_xlate.sv
`timescale 1ns/1ps
module vmem_xlate
    import vmx_pkg::*;
#(
    parameter int MEM_BYTES  = 196608,
    parameter int BANK_AW    = 8,
    parameter int PLANE_IN_W = 4,
    parameter int RS_W       = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_word_mode,
    input  logic                  cfg_wrap_msb,
    input  logic                  cfg_keep_a13,
    input  logic                  cfg_keep_a14,
    input  logic [RS_W-1:0]       row_scan,
    input  logic                  rd_en,
    input  logic [PLANE_IN_W-1:0] rd_plane,
    input  logic [15:0]           rd_offset,
    input  logic                  wr_en,
    input  logic [PLANE_IN_W-1:0] wr_plane,
    input  logic [15:0]           wr_offset,
    input  logic [7:0]            wr_data,
    output logic                  rd_valid_q,
    output logic [17:0]           rd_addr_q,
    output logic [7:0]            rd_data_q,
    output logic                  upd_valid_q,
    output logic [15:0]           upd_offset_q
);
    localparam int SUB_LO = 13;
    localparam int SUB_N  = 2;

    off_t        wrap_off, sub_off;
    phys_t       rd_phys, wr_phys;
    store_regs_t regs;

    vmx_wordwrap #(.OFF_W(OFF_W), .SRC_LO(13), .SRC_HI(15)) wrap_i (
        .off_i       (rd_offset),
        .word_mode_i (cfg_word_mode),
        .wrap_msb_i  (cfg_wrap_msb),
        .off_o       (wrap_off)
    );

    vmx_rowsub #(.OFF_W(OFF_W), .SUB_LO(SUB_LO), .SUB_N(SUB_N)) sub_i (
        .off_i  (wrap_off),
        .keep_i ({cfg_keep_a14, cfg_keep_a13}),
        .rs_i   (row_scan[SUB_N-1:0]),
        .off_o  (sub_off)
    );

    assign rd_phys = {rd_plane[PL_W-1:0], sub_off};
    assign wr_phys = {wr_plane[PL_W-1:0], wr_offset};

    vmx_store #(.MEM_BYTES(MEM_BYTES), .BANK_AW(BANK_AW), .CHR_PLANE(2)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .rd_phys_i (rd_phys),
        .wr_en_i   (wr_en),
        .wr_phys_i (wr_phys),
        .wr_data_i (wr_data),
        .regs_o    (regs)
    );

    if (PLANE_IN_W > PL_W) begin : g_plane_hi
        logic unused_plane_hi;
        assign unused_plane_hi = ^{rd_plane[PLANE_IN_W-1:PL_W], wr_plane[PLANE_IN_W-1:PL_W]};
    end
    if (RS_W > SUB_N) begin : g_rs_hi
        logic unused_rs_hi;
        assign unused_rs_hi = ^row_scan[RS_W-1:SUB_N];
    end

    assign rd_valid_q   = regs.rd_valid;
    assign rd_addr_q    = regs.rd_addr;
    assign rd_data_q    = regs.rd_data;
    assign upd_valid_q  = regs.upd_valid;
    assign upd_offset_q = regs.upd_offset;
endmodule

// File: rtl/vmem_xlate_chk.sv
`timescale 1ns/1ps
module vmem_xlate_chk #(
    parameter int MEM_BYTES = 196608
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_word_mode,
    input logic        cfg_wrap_msb,
    input logic        cfg_keep_a13,
    input logic        cfg_keep_a14,
    input logic [1:0]  rs_lo,
    input logic        rd_en,
    input logic [1:0]  rd_pl,
    input logic [15:0] rd_offset,
    input logic        wr_en,
    input logic [1:0]  wr_pl,
    input logic [15:0] wr_offset,
    input logic        rd_valid_q,
    input logic [17:0] rd_addr_q,
    input logic [7:0]  rd_data_q,
    input logic        upd_valid_q,
    input logic [15:0] upd_offset_q
);
    localparam logic [18:0] LIMIT = 19'(MEM_BYTES);

    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid_q);
    assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid_q);
    assert_plane_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_addr_q[17:16] == $past(rd_pl));
    assert_wrap_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cfg_word_mode && cfg_wrap_msb |=> rd_addr_q[0] == $past(rd_offset[15]));
    assert_wrap_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cfg_word_mode && !cfg_wrap_msb |=> rd_addr_q[0] == $past(rd_offset[13]));
    assert_sub13_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !cfg_keep_a13 |=> rd_addr_q[13] == $past(rs_lo[0]));
    assert_sub14_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !cfg_keep_a14 |=> rd_addr_q[14] == $past(rs_lo[1]));
    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_q && ({1'b0, rd_addr_q} >= LIMIT) |-> rd_data_q == 8'h00);
    assert_notify_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_pl == 2'd2 && ({1'b0, wr_pl, wr_offset} < LIMIT)
        |=> upd_valid_q && upd_offset_q == $past(wr_offset));
    assert_no_notify_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en || wr_pl != 2'd2 |=> !upd_valid_q);
endmodule

bind vmem_xlate vmem_xlate_chk #(.MEM_BYTES(MEM_BYTES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word_mode(cfg_word_mode),
    .cfg_wrap_msb (cfg_wrap_msb),
    .cfg_keep_a13 (cfg_keep_a13),
    .cfg_keep_a14 (cfg_keep_a14),
    .rs_lo        (row_scan[1:0]),
    .rd_en        (rd_en),
    .rd_pl        (rd_plane[1:0]),
    .rd_offset    (rd_offset),
    .wr_en        (wr_en),
    .wr_pl        (wr_plane[1:0]),
    .wr_offset    (wr_offset),
    .rd_valid_q   (rd_valid_q),
    .rd_addr_q    (rd_addr_q),
    .rd_data_q    (rd_data_q),
    .upd_valid_q  (upd_valid_q),
    .upd_offset_q (upd_offset_q)
);

// File: tb/vmem_xlate_tb.sv
`timescale 1ns/1ps
module vmem_xlate_tb_top;
    localparam int MEM_BYTES  = 32'h28000;
    localparam int BANK_AW    = 6;
    localparam int PLANE_IN_W = 8;
    localparam int RS_W       = 5;

    localparam logic [23:0] STIM [8] = '{
        24'h02_A001, 24'h00_0000, 24'hFD_FFFF, 24'h03_2000,
        24'h01_8000, 24'h02_4001, 24'h06_6002, 24'h00_1234
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_word_mode = 0, cfg_wrap_msb = 0, cfg_keep_a13 = 1, cfg_keep_a14 = 1;
    logic [RS_W-1:0] row_scan = '0;
    logic rd_en = 0;
    logic [PLANE_IN_W-1:0] rd_plane = '0;
    logic [15:0] rd_offset = '0;
    logic wr_en = 0;
    logic [PLANE_IN_W-1:0] wr_plane = '0;
    logic [15:0] wr_offset = '0;
    logic [7:0] wr_data = '0;
    logic rd_valid_q, upd_valid_q;
    logic [17:0] rd_addr_q;
    logic [7:0] rd_data_q;
    logic [15:0] upd_offset_q;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    vmem_xlate #(.MEM_BYTES(MEM_BYTES), .BANK_AW(BANK_AW),
                 .PLANE_IN_W(PLANE_IN_W), .RS_W(RS_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_word_mode(cfg_word_mode), .cfg_wrap_msb(cfg_wrap_msb),
        .cfg_keep_a13(cfg_keep_a13), .cfg_keep_a14(cfg_keep_a14),
        .row_scan(row_scan),
        .rd_en(rd_en), .rd_plane(rd_plane), .rd_offset(rd_offset),
        .wr_en(wr_en), .wr_plane(wr_plane), .wr_offset(wr_offset), .wr_data(wr_data),
        .rd_valid_q(rd_valid_q), .rd_addr_q(rd_addr_q), .rd_data_q(rd_data_q),
        .upd_valid_q(upd_valid_q), .upd_offset_q(upd_offset_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // control bits: [0] word mode, [1] wrap msb, [2] keep13, [3] keep14, [5:4] row scan
    function automatic logic [17:0] ref_addr(input logic [7:0] pl, input logic [15:0] off,
                                             input logic [5:0] c);
        logic [15:0] a;
        a = off;
        if (c[0]) a[0] = c[1] ? off[15] : off[13];
        if (!c[2]) a[13] = c[4];
        if (!c[3]) a[14] = c[5];
        return {pl[1:0], a};
    endfunction

    task automatic set_cfg(input logic [5:0] c);
        @(negedge clk);
        cfg_word_mode = c[0];
        cfg_wrap_msb  = c[1];
        cfg_keep_a13  = c[2];
        cfg_keep_a14  = c[3];
        row_scan      = {3'b101, c[5:4]};
    endtask

    task automatic do_rd(input logic [7:0] pl, input logic [15:0] off,
                         output logic v, output logic [17:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1; rd_plane = pl; rd_offset = off;
        @(posedge clk); #1;
        v = rd_valid_q; a = rd_addr_q; d = rd_data_q;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic do_wr(input logic [7:0] pl, input logic [15:0] off, input logic [7:0] dat,
                         output logic uv, output logic [15:0] uo);
        @(negedge clk);
        wr_en = 1; wr_plane = pl; wr_offset = off; wr_data = dat;
        @(posedge clk); #1;
        uv = upd_valid_q; uo = upd_offset_q;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic v, uv;
        logic [17:0] a;
        logic [7:0] d;
        logic [15:0] uo;

        repeat (3) @(posedge clk);
        #1;
        check("R1 rd_valid in reset", rd_valid_q, 0);
        check("R1 rd_data in reset", rd_data_q, 0);
        check("R1 upd_valid in reset", upd_valid_q, 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        check("R1 rd_valid after reset", rd_valid_q, 0);
        check("R1 upd_valid after reset", upd_valid_q, 0);

        // Reference sweep over every control combination (R2 R3 R4 R5 R6 R8)
        for (int c = 0; c < 64; c++) begin
            set_cfg(6'(c));
            for (int i = 0; i < 8; i++) begin
                logic [17:0] e;
                e = ref_addr(STIM[i][23:16], STIM[i][15:0], 6'(c));
                do_rd(STIM[i][23:16], STIM[i][15:0], v, a, d);
                check("R2 valid", v, 1);
                check("R3_R4_R6 address", a, e);
                if ({14'd0, e} >= MEM_BYTES) check("R8 oob zero", d, 0);
            end
        end

        // R2 identity and idle
        set_cfg(6'b001100);
        do_rd(8'h01, 16'h1357, v, a, d);
        check("R2 identity address", a, 18'h11357);
        @(posedge clk); #1;
        check("R2 valid drops", rd_valid_q, 0);

        // R5 ordering
        set_cfg(6'b001001);
        do_rd(8'h00, 16'h2000, v, a, d);
        check("R5 wrap before substitution", a, 18'h00001);

        // R10 host writes ignore translation
        set_cfg(6'b001100);
        do_wr(8'h00, 16'h0003, 8'h11, uv, uo);
        check("R11 no notify plane 0", uv, 0);
        set_cfg(6'b001001);
        do_wr(8'h00, 16'h2002, 8'h5A, uv, uo);
        set_cfg(6'b001100);
        do_rd(8'h00, 16'h2002, v, a, d);
        check("R10 untranslated store", d, 8'h5A);
        do_rd(8'h00, 16'h0003, v, a, d);
        check("R10 translated target untouched R7", d, 8'h11);

        // R11 notifications
        do_wr(8'h02, 16'h0010, 8'h77, uv, uo);
        check("R11 notify valid", uv, 1);
        check("R11 notify offset", uo, 16'h0010);
        do_wr(8'h01, 16'h0010, 8'h66, uv, uo);
        check("R11 no notify plane 1", uv, 0);
        do_wr(8'h02, 16'h8010, 8'h55, uv, uo);
        check("R11 no notify out of range", uv, 0);
        @(posedge clk); #1;
        check("R11 idle no notify", upd_valid_q, 0);

        // R6 plane masking on write, R7 readback
        do_wr(8'hF9, 16'h0021, 8'h9C, uv, uo);
        do_rd(8'h01, 16'h0021, v, a, d);
        check("R6 write plane masked R7", d, 8'h9C);

        // R9 dropped write, R8 boundary
        do_wr(8'h02, 16'h0005, 8'hA5, uv, uo);
        do_wr(8'h02, 16'h8005, 8'h3C, uv, uo);
        do_rd(8'h02, 16'h0005, v, a, d);
        check("R9 dropped write", d, 8'hA5);
        do_wr(8'h02, 16'h7FFF, 8'hC3, uv, uo);
        do_rd(8'h02, 16'h7FFF, v, a, d);
        check("R8 last in-range byte", d, 8'hC3);
        do_rd(8'h02, 16'h8000, v, a, d);
        check("R8 first out-of-range byte", d, 8'h00);
        do_rd(8'h03, 16'h0005, v, a, d);
        check("R8 plane 3 out of range", d, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule